// File: doc/BRIEF.md
# Link Activity Monitor

This block supervises one reliable, sequenced connection carried over a datagram transport. It receives one-cycle event pulses from the receive and transmit paths: a valid segment arrived, an acknowledge arrived, a data segment left. It also receives two levels: the transmit buffer still holds unacknowledged data, and the connection is up. From these it decides when the transmitter should resend outstanding data, when it should send an acknowledge, and when it should send an empty keep-alive segment.

A role input selects the server or the client side. A server watches for peer silence and raises a sticky flag when the peer stays quiet too long. A client keeps the link alive by asking for keep-alive segments whenever it has nothing else to send. Both roles count retransmissions and raise a sticky flag when the retry limit is reached.

All timeouts count in units of a timebase derived from the clock frequency, 1 ms by default at 156.25 MHz. The defaults are an acknowledge timeout of 25 units, a retransmit timeout of 50 units and a peer-silence timeout of 200 units. The retry limit defaults to 8 and the cumulative-acknowledge limit to 3 segments. A build-time switch removes retransmission entirely.

Top module: `link_activity_monitor`

## Requirements
- R1: A timebase tick fires once every CLK_HZ/UNITS_PER_SEC cycles while `conn_active_i` is high, with the first tick on the last cycle of the first period after the connection comes up. Every timer advances only on ticks.
- R2: While `conn_active_i` is low, every timer and counter is held at zero and no request output is asserted, whatever the event inputs do.
- R3: While the connection is up and `tx_buf_empty_i` is low, the retransmit timer counts ticks. On the tick that completes RETX_UNITS units, `resend_o` pulses for one cycle, the retry counter increments and saturates at RETRY_LIMIT, and the timer restarts.
- R4: A pulse on `rx_ack_i` clears the retransmit timer and the retry counter in that cycle, and it suppresses any expiry in that cycle.
- R5: `retry_max_o` is set by the resend that brings the retry counter to RETRY_LIMIT, and it stays set.
- R6: Each `rx_valid_i` pulse adds one pending segment. The pulse that brings the pending count to CUM_ACK_LIMIT raises `send_ack_o` in that same cycle, and the count returns to zero.
- R7: When at least one segment is pending and ACK_UNITS ticks have passed since the acknowledge timer started, `send_ack_o` pulses and the pending count and the timer return to zero.
- R8: With `server_mode_i` high, the silence timer restarts on each `rx_valid_i`. After NULL_UNITS units without one, `null_tout_o` is set in the next cycle and stays set.
- R9: With `server_mode_i` low, the keep-alive timer restarts on each `tx_data_i` and expires after RETX_UNITS units. `send_null_o` pulses at that expiry only if `tx_buf_empty_i` is high. The timer restarts in either case.
- R10: Both sticky flags clear on reset and in the cycle after `conn_active_i` rises.
- R11: With RETX_ENABLE at 0, `resend_o` and `retry_max_o` stay low and the retry count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| server_mode_i | input | 1 | 1 selects the server role, 0 selects the client role |
| conn_active_i | input | 1 | Connection is established |
| rx_valid_i | input | 1 | Pulse: a valid segment was received |
| rx_ack_i | input | 1 | Pulse: a valid acknowledge was received |
| tx_data_i | input | 1 | Pulse: a data segment was transmitted |
| tx_buf_empty_i | input | 1 | Level: no unacknowledged data is outstanding |
| resend_o | output | 1 | One-cycle request to retransmit outstanding data |
| send_ack_o | output | 1 | One-cycle request to send an acknowledge |
| send_null_o | output | 1 | One-cycle request to send a keep-alive segment |
| retry_max_o | output | 1 | Sticky: retry limit reached |
| null_tout_o | output | 1 | Sticky: peer silence timeout (server) |

## Verification
The bench builds two copies side by side with a two-cycle timebase, acknowledge, retransmit and silence timeouts of 3, 4 and 16 units, a retry limit of 3 and a cumulative limit of 3. One copy has retransmission enabled and the other has it disabled. With these values a peer-silence timeout, a run of resends that saturates the retry counter, several keep-alive periods and both acknowledge triggers all fit within a few hundred cycles. The disabled copy takes the same stimulus, so its quiet resend path can be compared against the enabled copy cycle by cycle.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // a timer running at 'count' completes its window on the next tick
  function automatic logic window_done(input int unsigned count,
                                       input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

  // saturating increment used by the retry counter
  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned ceiling);
    return (v >= ceiling) ? ceiling : v + 1;
  endfunction

endpackage

// File: rtl/lm_timebase.sv
module lm_timebase #(
  parameter int unsigned TICKS = 156250
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic tick
);
  import link_mon_pkg::*;
  localparam int unsigned W = cnt_width(TICKS);

  logic [W-1:0] pre_q;

  assign tick = active && (pre_q == W'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || tick) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/lm_timer.sv
module lm_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,     // clears and suppresses expiry
  input  logic         restart,  // clears without gating expiry
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire,
  output logic [W-1:0] count
);
  import link_mon_pkg::*;

  assign expire = run && tick && !hold && window_done(32'(count), 32'(limit));

  always_ff @(posedge clk) begin
    if (rst || hold || restart) count <= '0;
    else if (expire)            count <= '0;
    else if (run && tick)       count <= count + 1'b1;
  end
endmodule

// File: rtl/lm_retry.sv
module lm_retry #(
  parameter int unsigned RETX_UNITS  = 50,
  parameter int unsigned RETRY_LIMIT = 8,
  parameter bit          RETX_ENABLE = 1'b1,
  parameter int unsigned TW          = 8,
  parameter int unsigned RW          = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          conn_open,
  input  logic          tick,
  input  logic          outstanding,
  input  logic          rx_ack,
  output logic          resend,
  output logic [RW-1:0] retry_cnt,
  output logic          retry_max
);
  import link_mon_pkg::*;

  generate
    if (RETX_ENABLE) begin : g_on
      logic          expire;
      logic [TW-1:0] unused_cnt;
      logic [RW-1:0] cnt_q;
      logic          flag_q;

      lm_timer #(.W(TW)) u_rt (
        .clk(clk), .rst(rst),
        .hold(!active || rx_ack), .restart(1'b0),
        .run(active && outstanding), .tick(tick),
        .limit(TW'(RETX_UNITS)),
        .expire(expire), .count(unused_cnt)
      );

      always_ff @(posedge clk) begin
        if (rst || !active || rx_ack) cnt_q <= '0;
        else if (expire)              cnt_q <= RW'(sat_inc(32'(cnt_q), RETRY_LIMIT));
      end

      always_ff @(posedge clk) begin
        if (rst || conn_open) flag_q <= 1'b0;
        else if (expire && (32'(cnt_q) + 1 >= RETRY_LIMIT)) flag_q <= 1'b1;
      end

      assign resend    = expire;
      assign retry_cnt = cnt_q;
      assign retry_max = flag_q;
    end else begin : g_off
      assign resend    = 1'b0;
      assign retry_cnt = '0;
      assign retry_max = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/link_activity_monitor.sv
module link_activity_monitor #(
  parameter int unsigned CLK_HZ        = 156_250_000,
  parameter int unsigned UNITS_PER_SEC = 1000,
  parameter int unsigned ACK_UNITS     = 25,
  parameter int unsigned RETX_UNITS    = 50,
  parameter int unsigned NULL_UNITS    = 200,
  parameter int unsigned RETRY_LIMIT   = 8,
  parameter int unsigned CUM_ACK_LIMIT = 3,
  parameter bit          RETX_ENABLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic server_mode_i,
  input  logic conn_active_i,
  input  logic rx_valid_i,
  input  logic rx_ack_i,
  input  logic tx_data_i,
  input  logic tx_buf_empty_i,
  output logic resend_o,
  output logic send_ack_o,
  output logic send_null_o,
  output logic retry_max_o,
  output logic null_tout_o
);
  import link_mon_pkg::*;

  localparam int unsigned TICKS  = CLK_HZ / UNITS_PER_SEC;
  localparam int unsigned MAXT   = (NULL_UNITS > RETX_UNITS)
                                   ? ((NULL_UNITS > ACK_UNITS) ? NULL_UNITS : ACK_UNITS)
                                   : ((RETX_UNITS > ACK_UNITS) ? RETX_UNITS : ACK_UNITS);
  localparam int unsigned TW     = cnt_width(MAXT);
  localparam int unsigned RW     = cnt_width(RETRY_LIMIT);
  localparam int unsigned PW     = cnt_width(CUM_ACK_LIMIT);

  // named internal events
  logic          act_q;
  logic          conn_open;
  logic          unit_tick;
  logic [RW-1:0] retry_cnt;
  logic [PW-1:0] pend_cnt;
  logic          ack_expire;
  logic [TW-1:0] ack_count;
  logic          cum_hit;
  logic          null_expire;
  logic [TW-1:0] null_count;
  logic          null_hold;
  logic [TW-1:0] null_limit;
  logic          null_flag_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= conn_active_i;
  end
  assign conn_open = conn_active_i && !act_q;

  lm_timebase #(.TICKS(TICKS)) u_tb (
    .clk(clk), .rst(rst), .active(conn_active_i), .tick(unit_tick)
  );

  lm_retry #(
    .RETX_UNITS(RETX_UNITS), .RETRY_LIMIT(RETRY_LIMIT),
    .RETX_ENABLE(RETX_ENABLE), .TW(TW), .RW(RW)
  ) u_retry (
    .clk(clk), .rst(rst), .active(conn_active_i), .conn_open(conn_open),
    .tick(unit_tick), .outstanding(!tx_buf_empty_i), .rx_ack(rx_ack_i),
    .resend(resend_o), .retry_cnt(retry_cnt), .retry_max(retry_max_o)
  );

  // acknowledge aggregation
  assign cum_hit    = rx_valid_i && (pend_cnt == PW'(CUM_ACK_LIMIT - 1));
  assign send_ack_o = conn_active_i && (cum_hit || ack_expire);

  lm_timer #(.W(TW)) u_ack (
    .clk(clk), .rst(rst),
    .hold(!conn_active_i), .restart(send_ack_o),
    .run(pend_cnt != '0), .tick(unit_tick),
    .limit(TW'(ACK_UNITS)),
    .expire(ack_expire), .count(ack_count)
  );

  always_ff @(posedge clk) begin
    if (rst || !conn_active_i || send_ack_o) pend_cnt <= '0;
    else if (rx_valid_i)                     pend_cnt <= pend_cnt + 1'b1;
  end

  // peer silence (server) / keep-alive (client)
  assign null_limit = server_mode_i ? TW'(NULL_UNITS) : TW'(RETX_UNITS);
  assign null_hold  = !conn_active_i || (server_mode_i ? rx_valid_i : tx_data_i);

  lm_timer #(.W(TW)) u_null (
    .clk(clk), .rst(rst),
    .hold(null_hold), .restart(1'b0),
    .run(conn_active_i), .tick(unit_tick),
    .limit(null_limit),
    .expire(null_expire), .count(null_count)
  );

  assign send_null_o = !server_mode_i && null_expire && tx_buf_empty_i;

  always_ff @(posedge clk) begin
    if (rst || conn_open)                 null_flag_q <= 1'b0;
    else if (server_mode_i && null_expire) null_flag_q <= 1'b1;
  end
  assign null_tout_o = null_flag_q;

endmodule

// File: rtl/link_mon_checks.sv
module link_mon_checks #(
  parameter int unsigned RETRY_LIMIT   = 8,
  parameter int unsigned CUM_ACK_LIMIT = 3,
  parameter bit          RETX_ENABLE   = 1'b1,
  parameter int unsigned RW            = 4,
  parameter int unsigned PW            = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          server_mode_i,
  input logic          conn_active_i,
  input logic          rx_valid_i,
  input logic          rx_ack_i,
  input logic          tx_buf_empty_i,
  input logic          resend_o,
  input logic          send_ack_o,
  input logic          send_null_o,
  input logic          retry_max_o,
  input logic          null_tout_o,
  input logic          conn_open,
  input logic          unit_tick,
  input logic [RW-1:0] retry_cnt,
  input logic [PW-1:0] pend_cnt
);

  p_tick_gated_r1: assert property (@(posedge clk) disable iff (rst)
    unit_tick |-> conn_active_i);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !conn_active_i |-> !(resend_o || send_ack_o || send_null_o));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !conn_active_i |=> (retry_cnt == '0) && (pend_cnt == '0));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    rx_ack_i |-> !resend_o);

  p_ack_zeroes_r4: assert property (@(posedge clk) disable iff (rst)
    rx_ack_i |=> retry_cnt == '0);

  p_retry_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (resend_o && (32'(retry_cnt) + 1 >= RETRY_LIMIT)) |=> retry_max_o);

  p_cum_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (conn_active_i && rx_valid_i && (32'(pend_cnt) == CUM_ACK_LIMIT - 1)) |-> send_ack_o);

  p_pend_bound_r6: assert property (@(posedge clk) disable iff (rst)
    32'(pend_cnt) < CUM_ACK_LIMIT);

  p_ack_empties_r7: assert property (@(posedge clk) disable iff (rst)
    send_ack_o |=> pend_cnt == '0);

  p_null_role_r9: assert property (@(posedge clk) disable iff (rst)
    send_null_o |-> (!server_mode_i && tx_buf_empty_i));

  p_retry_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (retry_max_o && !conn_open) |=> retry_max_o);

  p_null_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (null_tout_o && !conn_open) |=> null_tout_o);

  p_open_clears_r10: assert property (@(posedge clk) disable iff (rst)
    conn_open |=> !null_tout_o);

  generate
    if (!RETX_ENABLE) begin : g_off_chk
      p_no_resend_r11: assert property (@(posedge clk) disable iff (rst)
        !resend_o && !retry_max_o && (retry_cnt == '0));
    end
  endgenerate

endmodule

bind link_activity_monitor link_mon_checks #(
  .RETRY_LIMIT(RETRY_LIMIT), .CUM_ACK_LIMIT(CUM_ACK_LIMIT),
  .RETX_ENABLE(RETX_ENABLE), .RW(RW), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .server_mode_i(server_mode_i),
  .conn_active_i(conn_active_i), .rx_valid_i(rx_valid_i), .rx_ack_i(rx_ack_i),
  .tx_buf_empty_i(tx_buf_empty_i), .resend_o(resend_o), .send_ack_o(send_ack_o),
  .send_null_o(send_null_o), .retry_max_o(retry_max_o), .null_tout_o(null_tout_o),
  .conn_open(conn_open), .unit_tick(unit_tick), .retry_cnt(retry_cnt),
  .pend_cnt(pend_cnt)
);

// File: tb/sim_link_activity_monitor.sv
`timescale 1ns/1ps
module sim_link_activity_monitor;
  localparam int TPU = 2, ACKU = 3, RETXU = 4, NULU = 16, RLIM = 3, CUM = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic srv = 1'b1, act = 1'b0, rv = 1'b0, ra = 1'b0, td = 1'b0, te = 1'b1;
  logic rs0, ak0, nl0, rm0, nt0;
  logic rs1, ak1, nl1, rm1, nt1;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  link_activity_monitor #(.CLK_HZ(TPU * 1000), .UNITS_PER_SEC(1000),
    .ACK_UNITS(ACKU), .RETX_UNITS(RETXU), .NULL_UNITS(NULU),
    .RETRY_LIMIT(RLIM), .CUM_ACK_LIMIT(CUM), .RETX_ENABLE(1'b1)) u0 (
    .clk(clk), .rst(rst), .server_mode_i(srv), .conn_active_i(act),
    .rx_valid_i(rv), .rx_ack_i(ra), .tx_data_i(td), .tx_buf_empty_i(te),
    .resend_o(rs0), .send_ack_o(ak0), .send_null_o(nl0),
    .retry_max_o(rm0), .null_tout_o(nt0));

  link_activity_monitor #(.CLK_HZ(TPU * 1000), .UNITS_PER_SEC(1000),
    .ACK_UNITS(ACKU), .RETX_UNITS(RETXU), .NULL_UNITS(NULU),
    .RETRY_LIMIT(RLIM), .CUM_ACK_LIMIT(CUM), .RETX_ENABLE(1'b0)) u1 (
    .clk(clk), .rst(rst), .server_mode_i(srv), .conn_active_i(act),
    .rx_valid_i(rv), .rx_ack_i(ra), .tx_data_i(td), .tx_buf_empty_i(te),
    .resend_o(rs1), .send_ack_o(ak1), .send_null_o(nl1),
    .retry_max_o(rm1), .null_tout_o(nt1));

  // behavioural reference state
  int m_pre, m_rt, m_rc, m_at, m_pend, m_nt;
  bit m_rmax, m_ntf, m_aq;
  int ev_resend, ev_ack, ev_null;

  task automatic chk(input string tag, input logic actual, input logic expect_v);
    checks++;
    if (actual !== expect_v) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, actual, expect_v);
    end
  endtask

  task automatic model_clear();
    m_pre = 0; m_rt = 0; m_rc = 0; m_at = 0; m_pend = 0; m_nt = 0;
    m_rmax = 0; m_ntf = 0; m_aq = 0;
  endtask

  task automatic step(input bit a, input bit s, input bit v, input bit k,
                      input bit d, input bit e);
    bit tick, rexp, aexp, sack, nh, nexp, snull, open;
    int lim;
    @(negedge clk);
    act = a; srv = s; rv = v; ra = k; td = d; te = e;
    #1;
    tick  = a && (m_pre == TPU - 1);
    rexp  = a && !e && tick && !k && (m_rt + 1 >= RETXU);
    aexp  = a && (m_pend != 0) && tick && (m_at + 1 >= ACKU);
    sack  = a && ((v && (m_pend == CUM - 1)) || aexp);
    lim   = s ? NULU : RETXU;
    nh    = !a || (s ? v : d);
    nexp  = tick && !nh && (m_nt + 1 >= lim);
    snull = !s && nexp && e;
    chk(a ? "R3 resend" : "R2 resend idle", rs0, rexp);
    chk(a ? "R6/R7 send_ack" : "R2 send_ack idle", ak0, sack);
    chk(a ? "R9 send_null" : "R2 send_null idle", nl0, snull);
    chk("R5 retry_max", rm0, m_rmax);
    chk("R8 null_tout", nt0, m_ntf);
    chk("R11 resend disabled", rs1, 1'b0);
    chk("R11 retry_max disabled", rm1, 1'b0);
    chk("R6 send_ack copy", ak1, sack);
    chk("R9 send_null copy", nl1, snull);
    chk("R8 null_tout copy", nt1, m_ntf);
    ev_resend += int'(rs0); ev_ack += int'(ak0); ev_null += int'(nl0);
    // advance the reference by one clock
    open = a && !m_aq;
    m_aq = a;
    m_pre = (!a || tick) ? 0 : m_pre + 1;
    if (!a || k) m_rt = 0; else if (rexp) m_rt = 0; else if (!e && tick) m_rt++;
    if (open) m_rmax = 0; else if (rexp && (m_rc + 1 >= RLIM)) m_rmax = 1;
    if (!a || k) m_rc = 0; else if (rexp) m_rc = (m_rc >= RLIM) ? RLIM : m_rc + 1;
    if (!a || sack) m_at = 0; else if ((m_pend != 0) && tick) m_at++;
    if (!a || sack) m_pend = 0; else if (v) m_pend++;
    if (nh || nexp) m_nt = 0; else if (tick) m_nt++;
    if (open) m_ntf = 0; else if (s && nexp) m_ntf = 1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    int first_flag;
    model_clear();
    ev_resend = 0; ev_ack = 0; ev_null = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2: link down, events ignored
    for (int i = 0; i < 8; i++) step(0, 1, i[0], i[1], i[2], i[0]);
    chk("R2 no requests while inactive", (ev_resend + ev_ack + ev_null) == 0, 1'b1);

    // R1/R8: server, silent peer; flag appears TPU*NULU cycles after opening
    first_flag = -1;
    for (int i = 0; i < 2 * NULU + 6; i++) begin
      step(1, 1, 0, 0, 0, 1);
      if (nt0 === 1'b1 && first_flag < 0) first_flag = i;
    end
    chk("R1 tick spacing to null flag", first_flag == TPU * NULU, 1'b1);

    // R10: close and reopen clears the sticky flag
    step(0, 1, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 1);
    chk("R10 null flag cleared on reopen", nt0, 1'b0);

    // R6: cumulative acknowledge
    ev_ack = 0;
    for (int i = 0; i < 24; i++) step(1, 1, (i % 4) == 0, 0, 0, 1);
    chk("R6 acks from cumulative limit", ev_ack >= 2, 1'b1);

    // R7: lone segment acknowledged by timer
    step(1, 1, 0, 0, 0, 1);
    while (u0.pend_cnt != 0) step(1, 1, 0, 0, 0, 1);
    ev_ack = 0;
    step(1, 1, 1, 0, 0, 1);
    for (int i = 0; i < 2 * ACKU * TPU + 4; i++) step(1, 1, 0, 0, 0, 1);
    chk("R7 single timed ack", ev_ack == 1, 1'b1);

    // R3/R5: outstanding data, no acks
    ev_resend = 0;
    for (int i = 0; i < TPU * RETXU * 4 + 4; i++) step(1, 1, i % 7 == 0, 0, 0, 0);
    chk("R3 resend count", ev_resend == 4, 1'b1);
    chk("R5 retry limit flag", rm0, 1'b1);

    // R4: frequent acks keep the retransmit timer from expiring
    ev_resend = 0;
    for (int i = 0; i < 36; i++) step(1, 1, 1, (i % 6) == 0, 0, 0);
    chk("R4 no resend under frequent acks", ev_resend == 0, 1'b1);
    chk("R5 retry flag still sticky", rm0, 1'b1);

    // R10 for retry flag, then R9 client keep-alive
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1);
    chk("R10 retry flag cleared on reopen", rm0, 1'b0);
    ev_null = 0;
    for (int i = 0; i < TPU * RETXU * 3; i++) step(1, 0, 0, 0, 0, 1);
    chk("R9 keep-alives while idle", ev_null == 3, 1'b1);
    ev_null = 0;
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, (i % 5) == 0, 1);
    chk("R9 data traffic restarts keep-alive", ev_null == 0, 1'b1);
    ev_null = 0;
    for (int i = 0; i < 24; i++) step(1, 0, 0, 0, 0, 0);
    chk("R9 no keep-alive with data outstanding", ev_null == 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule